// File: doc/BRIEF.md
# Stream-to-Memory Burst Write Channel

This block takes a word stream on a valid/ready input and writes it into external memory as fixed-length bursts. Each burst is first pushed, word by word, into the memory controller's write FIFO; once every word of the burst is in the FIFO, the block raises an address request carrying the burst's start address and size code. It holds that request until the controller acknowledges it. The address then moves on by the burst size in bytes.

A run is configured through plain inputs: a start address, a byte count, a burst-size code, a loop enable and a test enable. It begins on the rising edge of the run input. The byte count need not be a multiple of the burst size. The burst that carries the last data word is filled up with padding words, and a parameter selects whether these are all zeros or all ones. In loop mode the address returns to the start address after the final burst, and the transfer repeats until run is dropped. In test mode a 32-bit counter replaces the stream data. A second parameter reverses the byte order of stream words before they are pushed.

Back-pressure rules: `s_ready` is high only while the channel is filling a burst from the stream. It is low while the FIFO almost-full input is high, while the block pads, while it waits for an acknowledge, while it is idle, and throughout a test-mode run. A word moves on a clock edge where `s_valid` and `s_ready` are both high. The source may hold `s_valid` high for any number of cycles.

Top module: `strm_burst_wr`

## Requirements
- R1: After reset, `done` is 1 and `mem_addr_req`, `wf_push` and `s_ready` are 0.
- R2: The burst length in bytes follows `cfg_blk_code`: 0 gives one word (DW/8 bytes), 1 gives 16, 2 gives 32, 3 gives 64, 4 gives 128 and 5 gives 256. Code 5 is legal only when DW is 64. Any code above the largest legal one acts as the largest legal one. Each burst pushes bytes/(DW/8) words. `mem_size` carries the code that was latched at the run start.
- R3: A burst's address request rises only after its last word has been pushed. It stays high with a stable `mem_addr` until `mem_addr_ack`. Burst i of a run addresses start + i × burst bytes.
- R4: A run pushes ceil(byte count / (DW/8)) data words. The rest of the final burst is padding words, all zeros when PAD_ONES=0 and all ones when PAD_ONES=1.
- R5: While `wf_almost_full` is 1, `wf_push` and `s_ready` are 0. `fifo_full` is `wf_almost_full` delayed by one cycle.
- R6: With loop enabled, the acknowledge of the burst holding the final data word returns the address to the start address, and bursts continue. `done` stays 0. Dropping `cfg_run` returns the block to idle with `s_ready` 0.
- R7: With test enabled, the data words are a 32-bit counter, zero-extended to DW. It starts at 0 for each run and rises by one per data word. The stream is not consumed.
- R8: With SWAP_IN=1, the byte order of each stream word is reversed before the push (byte 0 moves to the top byte). Padding and test words are not reordered.
- R9: A rise of `cfg_run` with a nonzero byte count clears `done`. `done` is set when the final burst of a non-loop run is acknowledged, and `cur_addr` then equals start + bursts × burst bytes. A run with a zero byte count sets `done` at once and makes no pushes and no requests.
- R10: `mem_rnw` and `mem_rmw` are 0 and `wf_be` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_run | input | 1 | A rise starts a run; low stops it |
| cfg_start_addr | input | AW | Byte address of the first burst |
| cfg_byte_cnt | input | 32 | Bytes to transfer |
| cfg_blk_code | input | 4 | Burst-size code |
| cfg_loop | input | 1 | Repeat the region without end |
| cfg_test | input | 1 | Write counter words instead of stream data |
| s_data | input | DW | Stream word |
| s_valid | input | 1 | Stream word is valid |
| s_ready | output | 1 | Block accepts the stream word |
| wf_data | output | DW | Word to the write FIFO |
| wf_be | output | DW/8 | Byte enables (all ones) |
| wf_push | output | 1 | Push strobe to the write FIFO |
| wf_almost_full | input | 1 | Write FIFO almost full |
| mem_addr | output | AW | Burst byte address |
| mem_addr_req | output | 1 | Address request |
| mem_addr_ack | input | 1 | Address acknowledge |
| mem_rnw | output | 1 | Read-not-write (0) |
| mem_rmw | output | 1 | Read-modify-write (0) |
| mem_size | output | 4 | Burst-size code |
| done | output | 1 | Run complete |
| cur_addr | output | AW | Current burst address |
| fifo_full | output | 1 | Registered almost-full status |

## Verification
A wrong beat index or remaining-word count shows up at the FIFO port before the next address request. The words between two requests then differ from the burst length, or padding starts one word early or late. A wrong address register shows on `mem_addr` at the very next request, and, at the end of a run, on `cur_addr` in the cycle after the final acknowledge. A stuck or misrouted handshake shows within one cycle: the bench either sees stream words taken while almost-full is high, or sees the source index move during a test run.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_PAD, ST_REQ} sbw_state_e;

  localparam int unsigned SBW_BYTES_W = 10;

  // Burst length in bytes for a size code; codes past the widest legal one clamp.
  function automatic logic [SBW_BYTES_W-1:0] burst_bytes(input logic [3:0] code,
                                                         input int unsigned dw);
    logic [3:0] top_code;
    logic [3:0] c;
    top_code = (dw == 64) ? 4'd5 : 4'd4;
    c = (code > top_code) ? top_code : code;
    if (c == 4'd0) return SBW_BYTES_W'(dw / 8);
    return SBW_BYTES_W'(16) << (c - 4'd1);
  endfunction
endpackage

// File: rtl/sbw_size_dec.sv
module sbw_size_dec
  import sbw_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned BEAT_W = 9
) (
  input  logic [3:0]             code,
  output logic [SBW_BYTES_W-1:0] bytes,
  output logic [BEAT_W-1:0]      beats
);
  localparam int unsigned SH = $clog2(DW / 8);

  always_comb begin
    bytes = burst_bytes(code, DW);
    beats = BEAT_W'(bytes >> SH);
  end
endmodule

// File: rtl/sbw_swap.sv
module sbw_swap #(
  parameter int unsigned DW = 32,
  parameter bit          EN = 1'b0
) (
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  localparam int unsigned NB = DW / 8;

  generate
    if (EN) begin : g_rev
      for (genvar b = 0; b < NB; b++) begin : g_byte
        assign dout[8*b +: 8] = din[8*(NB-1-b) +: 8];
      end
    end else begin : g_pass
      assign dout = din;
    end
  endgenerate
endmodule

// File: rtl/sbw_addr_unit.sv
module sbw_addr_unit
  import sbw_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [AW-1:0]          base,
  input  logic                   adv,
  input  logic [SBW_BYTES_W-1:0] step,
  output logic [AW-1:0]          addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= base;
    else if (adv)  addr <= addr + AW'(step);
  end

  // R3: an advance moves the address by exactly one burst
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> addr == $past(addr) + AW'($past(step)));
endmodule

// File: rtl/strm_burst_wr.sv
module strm_burst_wr
  import sbw_pkg::*;
#(
  parameter int unsigned DW       = 32,
  parameter int unsigned AW       = 32,
  parameter bit          PAD_ONES = 1'b0,
  parameter bit          SWAP_IN  = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_run,
  input  logic [AW-1:0]   cfg_start_addr,
  input  logic [31:0]     cfg_byte_cnt,
  input  logic [3:0]      cfg_blk_code,
  input  logic            cfg_loop,
  input  logic            cfg_test,
  input  logic [DW-1:0]   s_data,
  input  logic            s_valid,
  output logic            s_ready,
  output logic [DW-1:0]   wf_data,
  output logic [DW/8-1:0] wf_be,
  output logic            wf_push,
  input  logic            wf_almost_full,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_addr_req,
  input  logic            mem_addr_ack,
  output logic            mem_rnw,
  output logic            mem_rmw,
  output logic [3:0]      mem_size,
  output logic            done,
  output logic [AW-1:0]   cur_addr,
  output logic            fifo_full
);
  localparam int unsigned BB     = DW / 8;
  localparam int unsigned SH     = $clog2(BB);
  localparam int unsigned BEAT_W = 9;

  sbw_state_e       state;
  logic             run_q, run_rise;
  logic [AW-1:0]    l_start;
  logic [31:0]      l_total, rem, total_beats;
  logic [3:0]       l_code;
  logic             l_loop, l_test;
  logic [BEAT_W-1:0] bidx, beats;
  logic [SBW_BYTES_W-1:0] bbytes;
  logic             dend, take, burst_last, ack_hs;
  logic [31:0]      tcnt;
  logic [DW-1:0]    s_swapped;
  logic             addr_load, addr_adv;
  logic [AW-1:0]    addr_base;

  assign run_rise    = cfg_run & ~run_q;
  assign total_beats = 32'(({1'b0, cfg_byte_cnt} + 33'(BB - 1)) >> SH);

  sbw_size_dec #(.DW(DW), .BEAT_W(BEAT_W)) u_size (
    .code(l_code), .bytes(bbytes), .beats(beats)
  );

  sbw_swap #(.DW(DW), .EN(SWAP_IN)) u_swap (
    .din(s_data), .dout(s_swapped)
  );

  // Handshake and FIFO side
  assign s_ready    = (state == ST_FILL) && !wf_almost_full && !l_test;
  assign take       = (state == ST_FILL) && !wf_almost_full && (l_test || s_valid);
  assign wf_push    = take || ((state == ST_PAD) && !wf_almost_full);
  assign burst_last = (bidx == beats - BEAT_W'(1));
  assign ack_hs     = (state == ST_REQ) && mem_addr_ack;

  always_comb begin
    if (state == ST_PAD) wf_data = PAD_ONES ? '1 : '0;
    else if (l_test)     wf_data = DW'(tcnt);
    else                 wf_data = s_swapped;
  end

  assign wf_be        = '1;
  assign mem_rnw      = 1'b0;
  assign mem_rmw      = 1'b0;
  assign mem_addr_req = (state == ST_REQ);
  assign mem_addr     = cur_addr;
  assign mem_size     = l_code;

  // Address register: reload on start or wrap, step after each other acknowledge
  assign addr_load = run_rise | (ack_hs & dend & l_loop);
  assign addr_base = run_rise ? cfg_start_addr : l_start;
  assign addr_adv  = ack_hs & ~(dend & l_loop);

  sbw_addr_unit #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(addr_load), .base(addr_base),
    .adv(addr_adv), .step(bbytes), .addr(cur_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      run_q     <= 1'b0;
      done      <= 1'b1;
      l_start   <= '0;
      l_total   <= '0;
      l_code    <= '0;
      l_loop    <= 1'b0;
      l_test    <= 1'b0;
      rem       <= '0;
      bidx      <= '0;
      dend      <= 1'b0;
      tcnt      <= '0;
      fifo_full <= 1'b0;
    end else begin
      run_q     <= cfg_run;
      fifo_full <= wf_almost_full;
      if (!cfg_run) begin
        state <= ST_IDLE;
      end else if (run_rise) begin
        l_start <= cfg_start_addr;
        l_total <= total_beats;
        l_code  <= cfg_blk_code;
        l_loop  <= cfg_loop;
        l_test  <= cfg_test;
        rem     <= total_beats;
        bidx    <= '0;
        dend    <= 1'b0;
        tcnt    <= '0;
        if (cfg_byte_cnt == 32'd0) begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end else begin
          done  <= 1'b0;
          state <= ST_FILL;
        end
      end else begin
        unique case (state)
          ST_FILL: if (take) begin
            rem <= rem - 32'd1;
            if (l_test) tcnt <= tcnt + 32'd1;
            if (burst_last) begin
              bidx  <= '0;
              dend  <= (rem == 32'd1);
              state <= ST_REQ;
            end else begin
              bidx <= bidx + BEAT_W'(1);
              if (rem == 32'd1) begin
                dend  <= 1'b1;
                state <= ST_PAD;
              end
            end
          end
          ST_PAD: if (!wf_almost_full) begin
            if (burst_last) begin
              bidx  <= '0;
              state <= ST_REQ;
            end else begin
              bidx <= bidx + BEAT_W'(1);
            end
          end
          ST_REQ: if (mem_addr_ack) begin
            if (!dend) begin
              state <= ST_FILL;
            end else if (l_loop) begin
              rem   <= l_total;
              dend  <= 1'b0;
              state <= ST_FILL;
            end else begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R3: request held with a stable address until acknowledged
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr_req && !mem_addr_ack && cfg_run) |=> (mem_addr_req && $stable(mem_addr)));

  // R3: a request only rises right after the burst's final push
  a_r3_req_after_push: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_addr_req) |-> $past(wf_push));

  // R5: nothing moves while the FIFO is almost full
  a_r5_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    wf_almost_full |-> (!wf_push && !s_ready));

  // R9: a nonzero run start clears done
  a_r9_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cfg_run) && cfg_byte_cnt != 32'd0) |=> !done);

  // R6: wrap returns the address to the start of the region
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hs && dend && l_loop && cfg_run) |=> (cur_addr == $past(l_start)));
endmodule

// File: tb/strm_burst_wr_tb.sv
module strm_burst_wr_tb;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 32;

  typedef struct packed {
    logic [3:0]  code;
    logic [31:0] bytes;
    logic        test;
    logic        bp;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{code: 4'd0, bytes: 32'd12,  test: 1'b0, bp: 1'b0},
    '{code: 4'd1, bytes: 32'd20,  test: 1'b0, bp: 1'b0},
    '{code: 4'd2, bytes: 32'd32,  test: 1'b0, bp: 1'b0},
    '{code: 4'd3, bytes: 32'd70,  test: 1'b0, bp: 1'b1},
    '{code: 4'd1, bytes: 32'd16,  test: 1'b1, bp: 1'b0},
    '{code: 4'd5, bytes: 32'd130, test: 1'b0, bp: 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_run = 1'b0, cfg_loop = 1'b0, cfg_test = 1'b0;
  logic [AW-1:0] cfg_start_addr = '0;
  logic [31:0] cfg_byte_cnt = '0;
  logic [3:0] cfg_blk_code = '0;
  logic [DW-1:0] s_data = '0;
  logic s_valid = 1'b0, wf_af = 1'b0, mem_ack = 1'b0;

  logic s_ready_a, push_a, req_a, rnw_a, rmw_a, done_a, ff_a;
  logic [DW-1:0] data_a;
  logic [DW/8-1:0] be_a;
  logic [AW-1:0] addr_a, cur_a;
  logic [3:0] size_a;
  logic s_ready_b, push_b, req_b, rnw_b, rmw_b, done_b, ff_b;
  logic [DW-1:0] data_b;
  logic [DW/8-1:0] be_b;
  logic [AW-1:0] addr_b, cur_b;
  logic [3:0] size_b;

  always #10 clk = ~clk;

  strm_burst_wr #(.DW(DW), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_run(cfg_run), .cfg_start_addr(cfg_start_addr),
    .cfg_byte_cnt(cfg_byte_cnt), .cfg_blk_code(cfg_blk_code), .cfg_loop(cfg_loop),
    .cfg_test(cfg_test), .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready_a),
    .wf_data(data_a), .wf_be(be_a), .wf_push(push_a), .wf_almost_full(wf_af),
    .mem_addr(addr_a), .mem_addr_req(req_a), .mem_addr_ack(mem_ack),
    .mem_rnw(rnw_a), .mem_rmw(rmw_a), .mem_size(size_a), .done(done_a),
    .cur_addr(cur_a), .fifo_full(ff_a)
  );

  strm_burst_wr #(.DW(DW), .AW(AW), .PAD_ONES(1'b1), .SWAP_IN(1'b1)) u_alt (
    .clk(clk), .rst_n(rst_n), .cfg_run(cfg_run), .cfg_start_addr(cfg_start_addr),
    .cfg_byte_cnt(cfg_byte_cnt), .cfg_blk_code(cfg_blk_code), .cfg_loop(cfg_loop),
    .cfg_test(cfg_test), .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready_b),
    .wf_data(data_b), .wf_be(be_b), .wf_push(push_b), .wf_almost_full(wf_af),
    .mem_addr(addr_b), .mem_addr_req(req_b), .mem_addr_ack(mem_ack),
    .mem_rnw(rnw_b), .mem_rmw(rmw_b), .mem_size(size_b), .done(done_b),
    .cur_addr(cur_b), .fifo_full(ff_b)
  );

  int n_chk = 0, n_bad = 0;
  int idx = 0, na = 0, nb = 0, nadr = 0, cyc_n = 0;
  logic bp_en = 1'b0, ack_nxt = 1'b0, prev_af = 1'b0;
  int hs_bad = 0, side_bad = 0;
  logic [DW-1:0] cap_a [256];
  logic [DW-1:0] cap_b [256];
  logic [AW-1:0] adr_q [32];
  logic [3:0] size_q [32];

  function automatic logic [31:0] stim(input int k);
    return 32'h1122_3300 + 32'(k);
  endfunction

  function automatic logic [31:0] rev(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic int bb_of(input logic [3:0] c);
    logic [3:0] k;
    k = (c > 4'd4) ? 4'd4 : c;
    return (k == 4'd0) ? 4 : (16 << (k - 1));
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
    s_data  = stim(idx);
    wf_af   = bp_en ? ((cyc_n % 3) == 0) : 1'b0;
    mem_ack = ack_nxt;
    #8;
    if (push_a && na < 256) begin cap_a[na] = data_a; na++; end
    if (push_b && nb < 256) begin cap_b[nb] = data_b; nb++; end
    if (s_ready_a && (push_a || wf_af)) ; // observation only
    if (wf_af && (s_ready_a || push_a)) hs_bad++;
    if (ff_a !== prev_af) hs_bad++;
    if (rnw_a !== 1'b0 || rmw_a !== 1'b0 || be_a !== '1) side_bad++;
    if (s_valid && s_ready_a) idx++;
    if (req_a && mem_ack && nadr < 32) begin
      adr_q[nadr] = addr_a; size_q[nadr] = size_a; nadr++;
    end
    ack_nxt = req_a && !mem_ack;
    prev_af = wf_af;
    cyc_n++;
  endtask

  task automatic start_run(input logic [AW-1:0] sa, input logic [31:0] nbytes,
                           input logic [3:0] code, input logic lp, input logic tst);
    cfg_start_addr = sa; cfg_byte_cnt = nbytes; cfg_blk_code = code;
    cfg_loop = lp; cfg_test = tst;
    idx = 0; na = 0; nb = 0; nadr = 0; hs_bad = 0; side_bad = 0;
    cfg_run = 1'b1;
  endtask

  initial begin
    s_valid = 1'b1;
    #35;
    // R1: reset state
    check(done_a === 1'b1, "R1 done at reset", 64'(done_a), 64'd1);
    check(req_a === 1'b0 && push_a === 1'b0, "R1 req/push at reset",
          64'({req_a, push_a}), 64'd0);
    rst_n = 1'b1;
    tick();
    check(s_ready_a === 1'b0, "R1 s_ready idle", 64'(s_ready_a), 64'd0);

    for (int v = 0; v < NV; v++) begin
      vec_t   t;
      int     bb, beats, nbur, ndata, wbad_a, wbad_b, abad, sbad;
      logic [AW-1:0] sa;
      bit     finished;
      t = VECS[v];
      bb = bb_of(t.code); beats = bb / 4;
      nbur = (int'(t.bytes) + bb - 1) / bb;
      ndata = (int'(t.bytes) + 3) / 4;
      sa = 32'h1000_0000 + 32'(v) * 32'h0001_0000;
      bp_en = t.bp;
      start_run(sa, t.bytes, t.code, 1'b0, t.test);
      finished = 1'b0;
      for (int c = 0; c < 3000; c++) begin
        tick();
        if (done_a) begin finished = 1'b1; break; end
      end
      check(finished, "R9 done set (watchdog)", 64'(finished), 64'd1);
      cfg_run = 1'b0; bp_en = 1'b0;
      tick();
      // R2: word count per run = bursts x beats
      check(na == nbur * beats, "R2 words pushed", 64'(na), 64'(nbur * beats));
      wbad_a = 0; wbad_b = 0;
      for (int k = 0; k < na && k < 256; k++) begin
        logic [31:0] ea, eb;
        if (k < ndata) begin
          ea = t.test ? 32'(k) : stim(k);
          eb = t.test ? 32'(k) : rev(stim(k));
        end else begin
          ea = 32'h0; eb = 32'hFFFF_FFFF;
        end
        if (cap_a[k] !== ea) wbad_a++;
        if (k < nb && cap_b[k] !== eb) wbad_b++;
      end
      // R4 data then zero padding; R7 counter words in test mode
      check(wbad_a == 0, t.test ? "R7 counter words" : "R4 data/zero pad words",
            64'(wbad_a), 64'd0);
      check(wbad_b == 0 && nb == na, "R8 swapped data / ones pad", 64'(wbad_b), 64'd0);
      abad = 0; sbad = 0;
      for (int i = 0; i < nadr; i++) begin
        if (adr_q[i] !== sa + 32'(i * bb)) abad++;
        if (size_q[i] !== t.code) sbad++;
      end
      check(nadr == nbur && abad == 0, "R3 burst addresses", 64'(nadr), 64'(nbur));
      check(sbad == 0, "R2 size code on request", 64'(sbad), 64'd0);
      check(cur_a === sa + 32'(nbur * bb), "R9 final cur_addr", 64'(cur_a),
            64'(sa + 32'(nbur * bb)));
      check(hs_bad == 0, "R5 back-pressure / fifo_full", 64'(hs_bad), 64'd0);
      check(side_bad == 0, "R10 rnw/rmw/be", 64'(side_bad), 64'd0);
      if (t.test) check(idx == 0, "R7 stream not consumed", 64'(idx), 64'd0);
    end

    // R6: loop wrap, 20 bytes at 16-byte bursts -> S, S+16, S, S+16 ...
    begin
      int abad;
      start_run(32'h2000_0000, 32'd20, 4'd1, 1'b1, 1'b0);
      for (int c = 0; c < 2000 && nadr < 6; c++) tick();
      abad = 0;
      for (int i = 0; i < 6; i++)
        if (adr_q[i] !== 32'h2000_0000 + ((i % 2) ? 32'd16 : 32'd0)) abad++;
      check(nadr >= 6 && abad == 0, "R6 loop wrap addresses", 64'(abad), 64'd0);
      check(done_a === 1'b0, "R6 done stays low in loop", 64'(done_a), 64'd0);
      cfg_run = 1'b0;
      tick();
      tick();
      check(s_ready_a === 1'b0 && req_a === 1'b0, "R6 stop returns to idle",
            64'({s_ready_a, req_a}), 64'd0);
    end

    // R9: zero byte count completes at once without traffic
    begin
      start_run(32'h3000_0000, 32'd0, 4'd2, 1'b0, 1'b0);
      tick();
      check(done_a === 1'b1, "R9 zero count done", 64'(done_a), 64'd1);
      tick();
      check(na == 0 && nadr == 0, "R9 zero count no traffic", 64'(na + nadr), 64'd0);
      cfg_run = 1'b0;
      tick();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #3_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule